// File: doc/BRIEF.md
# Shared PWM Generator Bank

This block holds a small pool of pulse-width waveform generators and lets a much larger set of output channels borrow them. Each generator is described by a period, counted in strobes of an external slow timebase (one strobe every 4 ms in the intended system), and by a pair of high and low weights that split each period into a high part followed by a low part. Every output channel has a map entry that either leaves the channel parked low or points it at one generator. Any number of channels can follow the same generator, and all of them then carry the same waveform.

With default parameters there are eight generators and thirty-three channels. The lower sixteen channels leave on a direct pin bus. The upper seventeen leave on a separate bit bus that a serializer elsewhere shifts out. Software programs everything through a single-cycle word write port. Generator settings are written to shadow copies. Each generator only loads them when its running period ends, so a change never cuts a period short. Map changes take effect immediately.

Top module: `pwm_gen_bank`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every channel output is low. After reset every map entry is disabled and every generator has period 1, high weight 0 and low weight 255.
- R2: Map entries live at word addresses 6 to 10. Channel k sits at word 6+k/8, bits 4*(k%8)+3 down to 4*(k%8). Within the entry, bit 3 is the enable and bits 2:0 are the generator index. An enabled channel output equals the level of the selected generator, delayed by one clock. A map write changes the output on the clock after the write.
- R3: A channel whose map enable bit is 0 drives 0, whatever generator index it holds.
- R4: Period fields live at word addresses 4 and 5. Generator g sits at word 4+g/4, bits 8*(g%4)+7 down to 8*(g%4). A period P counts P tick strobes, so the position n within the period runs from 0 to P-1 and then returns to 0. A period of 0 behaves as 1.
- R5: Duty words live at addresses 0 to 3. Generator g sits at word g/2, with its high weight H in bits 16*(g%2)+7 down to 16*(g%2) and its low weight L in the next 8 bits. At position n the generator is high exactly when n*(H+L) < P*H. A tick strobe changes the channel outputs two clocks later.
- R6: H=255 with L=0 holds a generator high for the whole period. H=0 holds it low for the whole period, for any L.
- R7: Writes to period or duty fields only update shadow values. A generator copies its shadow period, H and L into its active set on the tick that ends its running period. Earlier ticks keep the old values.
- R8: Two enabled channels that select the same generator produce identical outputs on every clock.
- R9: Channels 0 to 15 appear on `pin_o[k]`. Channels 16 to 32 appear on `ser_o[k-16]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase strobe that advances every generator |
| wr_en_i | input | 1 | Word write enable |
| wr_addr_i | input | ADDR_W (4) | Word address of the write |
| wr_data_i | input | 32 | Write data |
| pin_o | output | NUM_PIN (16) | Registered outputs of channels 0 to 15 |
| ser_o | output | NUM_CH-NUM_PIN (17) | Registered outputs of channels 16 to 32, for the serializer |

## Verification
The hardest case to reach is a generator write that lands in the middle of a running period. The check must show that the old waveform continues until the wrap tick and that the new one starts exactly there. A directed sequence brings a six-tick generator to a known position, rewrites it from always-high to always-low, and then checks the channel both before and after the boundary. In randomized rounds, generators are rewritten partway through their periods while random map words put many channels on the same generator. These rounds cover shared routing and staggered commits at the same time. A bench model of every generator's position and its shadow and active sets predicts all 33 outputs after each tick.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

  localparam int WORD_W = 32;
  localparam int PER_W  = 8;
  localparam int DUTY_W = 8;
  localparam int MAP_W  = 4;
  localparam int IDX_W  = MAP_W - 1;

  // generator settings, used both as shadow and active copy
  typedef struct packed {
    logic [PER_W-1:0]  per;
    logic [DUTY_W-1:0] hi;
    logic [DUTY_W-1:0] lo;
  } gen_cfg_t;

  localparam gen_cfg_t CFG_RST = '{per: 8'd1, hi: 8'd0, lo: 8'd255};

endpackage

// File: rtl/pwmb_regs.sv
module pwmb_regs
  import pwmb_pkg::*;
#(
  parameter int NUM_GEN = 8,
  parameter int NUM_CH  = 33,
  parameter int ADDR_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [WORD_W-1:0]               wr_data_i,
  output gen_cfg_t [NUM_GEN-1:0]          shadow_o,
  output logic [NUM_CH-1:0][MAP_W-1:0]    map_o
);

  localparam int DUTY_PER_WORD = WORD_W / (2 * DUTY_W);
  localparam int PER_PER_WORD  = WORD_W / PER_W;
  localparam int MAP_PER_WORD  = WORD_W / MAP_W;
  localparam int DUTY_WORDS    = (NUM_GEN + DUTY_PER_WORD - 1) / DUTY_PER_WORD;
  localparam int PER_WORDS     = (NUM_GEN + PER_PER_WORD - 1) / PER_PER_WORD;
  localparam int PER_BASE      = DUTY_WORDS;
  localparam int MAP_BASE      = PER_BASE + PER_WORDS;

  gen_cfg_t [NUM_GEN-1:0]       shadow_q;
  logic [NUM_CH-1:0][MAP_W-1:0] map_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NUM_GEN; g++) shadow_q[g] <= CFG_RST;
      map_q <= '0;
    end else if (wr_en_i) begin
      for (int g = 0; g < NUM_GEN; g++) begin
        if (int'(wr_addr_i) == g / DUTY_PER_WORD) begin
          shadow_q[g].hi <= wr_data_i[(g % DUTY_PER_WORD) * 2 * DUTY_W +: DUTY_W];
          shadow_q[g].lo <= wr_data_i[(g % DUTY_PER_WORD) * 2 * DUTY_W + DUTY_W +: DUTY_W];
        end
        if (int'(wr_addr_i) == PER_BASE + g / PER_PER_WORD)
          shadow_q[g].per <= wr_data_i[(g % PER_PER_WORD) * PER_W +: PER_W];
      end
      for (int k = 0; k < NUM_CH; k++) begin
        if (int'(wr_addr_i) == MAP_BASE + k / MAP_PER_WORD)
          map_q[k] <= wr_data_i[(k % MAP_PER_WORD) * MAP_W +: MAP_W];
      end
    end
  end

  assign shadow_o = shadow_q;
  assign map_o    = map_q;

endmodule

// File: rtl/pwmb_gen.sv
module pwmb_gen
  import pwmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  gen_cfg_t         shadow_i,
  output logic             level_o,
  output logic             wrap_o,
  output logic [PER_W-1:0] act_per_o,
  output logic [PER_W-1:0] cnt_o
);

  localparam int PROD_W = PER_W + DUTY_W + 1;

  gen_cfg_t           act_q;
  logic [PER_W-1:0]   cnt_q;
  logic               level_q;
  logic [PER_W-1:0]   per_eff;
  logic               at_end;
  logic [DUTY_W:0]    span;
  logic [PROD_W-1:0]  lhs;
  logic [PROD_W-1:0]  rhs;
  logic               high_now;

  always_comb begin
    per_eff  = (act_q.per == '0) ? PER_W'(1) : act_q.per;
    at_end   = ({1'b0, cnt_q} + (PER_W + 1)'(1)) >= {1'b0, per_eff};
    span     = {1'b0, act_q.hi} + {1'b0, act_q.lo};
    lhs      = PROD_W'(cnt_q) * PROD_W'(span);
    rhs      = PROD_W'(per_eff) * PROD_W'(act_q.hi);
    high_now = lhs < rhs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= CFG_RST;
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else begin
      level_q <= high_now;
      if (tick_i) begin
        if (at_end) begin
          cnt_q <= '0;
          act_q <= shadow_i;
        end else begin
          cnt_q <= cnt_q + PER_W'(1);
        end
      end
    end
  end

  assign level_o   = level_q;
  assign wrap_o    = tick_i & at_end;
  assign act_per_o = act_q.per;
  assign cnt_o     = cnt_q;

endmodule

// File: rtl/pwmb_route.sv
module pwmb_route
  import pwmb_pkg::*;
#(
  parameter int NUM_GEN = 8,
  parameter int NUM_CH  = 33
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH-1:0][MAP_W-1:0] map_i,
  input  logic [NUM_GEN-1:0]           level_i,
  output logic [NUM_CH-1:0]            ch_o
);

  logic [NUM_CH-1:0] sel;
  logic [NUM_CH-1:0] ch_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
    if (NUM_GEN == (1 << IDX_W)) begin : g_full
      assign sel[k] = map_i[k][MAP_W-1] & level_i[map_i[k][IDX_W-1:0]];
    end else begin : g_part
      logic [(1<<IDX_W)-1:0] lvl_ext;
      assign lvl_ext = {{((1<<IDX_W)-NUM_GEN){1'b0}}, level_i};
      assign sel[k]  = map_i[k][MAP_W-1] & lvl_ext[map_i[k][IDX_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ch_q <= '0;
    else     ch_q <= sel;
  end

  assign ch_o = ch_q;

endmodule

// File: rtl/pwm_gen_bank.sv
module pwm_gen_bank
  import pwmb_pkg::*;
#(
  parameter int NUM_GEN = 8,
  parameter int NUM_CH  = 33,
  parameter int NUM_PIN = 16,
  parameter int ADDR_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [WORD_W-1:0]         wr_data_i,
  output logic [NUM_PIN-1:0]        pin_o,
  output logic [NUM_CH-NUM_PIN-1:0] ser_o
);

  gen_cfg_t [NUM_GEN-1:0]           shadow;
  logic [NUM_CH-1:0][MAP_W-1:0]     map_w;
  logic [NUM_GEN-1:0]               gen_level;
  logic [NUM_GEN-1:0]               gen_wrap;
  logic [NUM_GEN-1:0][PER_W-1:0]    gen_act_per;
  logic [NUM_GEN-1:0][PER_W-1:0]    gen_cnt;
  logic [NUM_CH-1:0]                ch_out;

  pwmb_regs #(
    .NUM_GEN(NUM_GEN), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .shadow_o(shadow), .map_o(map_w)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    pwmb_gen u_gen (
      .clk(clk), .rst(rst), .tick_i(tick_i),
      .shadow_i(shadow[g]),
      .level_o(gen_level[g]), .wrap_o(gen_wrap[g]),
      .act_per_o(gen_act_per[g]), .cnt_o(gen_cnt[g])
    );
  end

  pwmb_route #(
    .NUM_GEN(NUM_GEN), .NUM_CH(NUM_CH)
  ) u_route (
    .clk(clk), .rst(rst),
    .map_i(map_w), .level_i(gen_level), .ch_o(ch_out)
  );

  assign pin_o = ch_out[NUM_PIN-1:0];
  assign ser_o = ch_out[NUM_CH-1:NUM_PIN];

endmodule

// File: rtl/pwmb_checker.sv
module pwmb_checker
  import pwmb_pkg::*;
#(
  parameter int NUM_GEN = 8,
  parameter int NUM_CH  = 33,
  parameter int NUM_PIN = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_CH*MAP_W-1:0]     map_i,
  input logic [NUM_GEN-1:0]          level_i,
  input logic [NUM_GEN-1:0]          wrap_i,
  input logic [NUM_GEN*PER_W-1:0]    act_per_i,
  input logic [NUM_GEN*PER_W-1:0]    cnt_i,
  input logic [NUM_PIN-1:0]          pin_i,
  input logic [NUM_CH-NUM_PIN-1:0]   ser_i
);

  logic [NUM_CH-1:0] ch;
  assign ch = {ser_i, pin_i};

  logic rst_seen_q = 1'b0;

  // R1: outputs are clear right after a reset cycle
  always_ff @(posedge clk) begin
    if (rst_seen_q) a_r1_reset_clears: assert (ch == '0);
    rst_seen_q <= rst;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    a_r3_disabled_low: assert property (@(posedge clk) disable iff (rst)
      !map_i[k*MAP_W + IDX_W] |=> !ch[k]);

    a_r2_follows_gen: assert property (@(posedge clk) disable iff (rst)
      map_i[k*MAP_W + IDX_W] |=> (ch[k] == $past(level_i[map_i[k*MAP_W +: IDX_W]])));

    if (k < NUM_CH - 1) begin : g_pair
      a_r8_shared_equal: assert property (@(posedge clk) disable iff (rst)
        (map_i[k*MAP_W + IDX_W] && map_i[(k+1)*MAP_W + IDX_W] &&
         map_i[k*MAP_W +: IDX_W] == map_i[(k+1)*MAP_W +: IDX_W])
        |=> (ch[k] == ch[k+1]));
    end
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_g
    a_r7_hold_until_wrap: assert property (@(posedge clk) disable iff (rst)
      !wrap_i[g] |=> $stable(act_per_i[g*PER_W +: PER_W]));

    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
      (cnt_i[g*PER_W +: PER_W] == '0) ||
      (cnt_i[g*PER_W +: PER_W] < act_per_i[g*PER_W +: PER_W]));
  end

endmodule

bind pwm_gen_bank pwmb_checker #(
  .NUM_GEN(NUM_GEN), .NUM_CH(NUM_CH), .NUM_PIN(NUM_PIN)
) u_chk (
  .clk(clk), .rst(rst),
  .map_i(map_w), .level_i(gen_level), .wrap_i(gen_wrap),
  .act_per_i(gen_act_per), .cnt_i(gen_cnt),
  .pin_i(pin_o), .ser_i(ser_o)
);

// File: tb/test_pwm_gen_bank.sv
module test_pwm_gen_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NG = 8;
  localparam int NC = 33;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NP-1:0]    pin_o;
  logic [NC-NP-1:0] ser_o;

  pwm_gen_bank #(.NUM_GEN(NG), .NUM_CH(NC), .NUM_PIN(NP), .ADDR_W(4)) i_pwm_gen_bank (
    .clk(clk), .rst(rst), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pin_o(pin_o), .ser_o(ser_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model
  int sh_p[NG], sh_h[NG], sh_l[NG];
  int ac_p[NG], ac_h[NG], ac_l[NG], pos[NG];
  int m_en[NC], m_idx[NC];
  int n_chk = 0;
  int n_fail = 0;

  task automatic check_bit(input string tag, input int ch, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s ch%0d actual=%0b expected=%0b", tag, ch, act, exp);
    end
  endtask

  function automatic logic exp_level(input int g);
    int pe;
    pe = (ac_p[g] == 0) ? 1 : ac_p[g];
    return (pos[g] * (ac_h[g] + ac_l[g])) < (pe * ac_h[g]);
  endfunction

  function automatic logic exp_ch(input int k);
    return (m_en[k] != 0) ? exp_level(m_idx[k]) : 1'b0;
  endfunction

  function automatic logic got_ch(input int k);
    return (k < NP) ? pin_o[k] : ser_o[k-NP];
  endfunction

  task automatic sweep(input string tag_en);
    for (int k = 0; k < NC; k++)
      check_bit((m_en[k] != 0) ? tag_en : "R3", k, got_ch(k), exp_ch(k));
  endtask

  task automatic wr_word(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_gen(input int g, input int p, input int h, input int l);
    int w;
    sh_p[g] = p; sh_h[g] = h; sh_l[g] = l;
    w = g / 2;
    wr_word(w, {8'(sh_l[2*w+1]), 8'(sh_h[2*w+1]), 8'(sh_l[2*w]), 8'(sh_h[2*w])});
    w = g / 4;
    wr_word(4 + w, {8'(sh_p[4*w+3]), 8'(sh_p[4*w+2]), 8'(sh_p[4*w+1]), 8'(sh_p[4*w])});
  endtask

  task automatic write_map_word(input int w);
    logic [31:0] d;
    d = '0;
    for (int j = 0; j < 8; j++) begin
      if (8*w + j < NC) d[4*j +: 4] = {1'(m_en[8*w+j]), 3'(m_idx[8*w+j])};
    end
    wr_word(6 + w, d);
  endtask

  task automatic set_map(input int k, input int en, input int idx);
    m_en[k] = en; m_idx[k] = idx;
    write_map_word(k / 8);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    for (int g = 0; g < NG; g++) begin
      int pe;
      pe = (ac_p[g] == 0) ? 1 : ac_p[g];
      if (pos[g] + 1 >= pe) begin
        pos[g] = 0; ac_p[g] = sh_p[g]; ac_h[g] = sh_h[g]; ac_l[g] = sh_l[g];
      end else begin
        pos[g]++;
      end
    end
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h;
    void'($urandom(32'd4817));
    for (int g = 0; g < NG; g++) begin
      sh_p[g] = 1; sh_h[g] = 0; sh_l[g] = 255;
      ac_p[g] = 1; ac_h[g] = 0; ac_l[g] = 255; pos[g] = 0;
    end
    for (int k = 0; k < NC; k++) begin m_en[k] = 0; m_idx[k] = 0; end

    repeat (4) @(negedge clk);
    check_bit("R1", 0, pin_o[0], 1'b0);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NC; k++) check_bit("R1", k, got_ch(k), 1'b0);

    // R4: five-tick period, one tick high; R8: ch0 and ch20 share gen0
    set_gen(0, 5, 1, 254);
    set_map(0, 1, 0);
    set_map(20, 1, 0);
    set_map(5, 0, 0);
    for (int t = 0; t < 11; t++) begin
      do_tick();
      sweep("R4");
      check_bit("R8", 20, ser_o[4], pin_o[0]);
    end

    // R9: pin/serial placement with an always-high generator
    set_gen(1, 250, 255, 0);
    set_map(15, 1, 1);
    set_map(16, 1, 1);
    set_map(32, 1, 1);
    do_tick();
    check_bit("R9", 15, pin_o[15], 1'b1);
    check_bit("R9", 16, ser_o[0], 1'b1);
    check_bit("R9", 32, ser_o[16], 1'b1);
    check_bit("R3", 31, ser_o[15], 1'b0);

    // R6: zero-weight cases and full duty
    set_gen(2, 3, 0, 0);
    set_gen(6, 4, 0, 255);
    set_map(1, 1, 2);
    set_map(2, 1, 6);
    set_map(3, 1, 1);
    for (int t = 0; t < 6; t++) begin
      do_tick();
      sweep("R6");
      check_bit("R6", 3, pin_o[3], 1'b1);
    end

    // R7: rewrite mid-period, old values hold to the wrap
    set_gen(3, 6, 255, 0);
    set_map(7, 1, 3);
    do_tick();
    do_tick();
    do_tick();
    set_gen(3, 6, 0, 255);
    do_tick();
    check_bit("R7", 7, pin_o[7], 1'b1);
    do_tick();
    do_tick();
    check_bit("R7", 7, pin_o[7], 1'b1);
    do_tick();
    check_bit("R7", 7, pin_o[7], 1'b0);
    sweep("R7");

    // R5: split duty, including non-complementary weights
    set_gen(4, 8, 100, 155);
    set_gen(5, 7, 3, 5);
    set_map(10, 1, 4);
    set_map(25, 1, 5);
    for (int t = 0; t < 16; t++) begin
      do_tick();
      sweep("R5");
    end

    // R2: randomized programming and routing
    for (int r = 0; r < 25; r++) begin
      for (int g = 0; g < NG; g++) begin
        if ($urandom % 2 == 1) begin
          case ($urandom % 3)
            0: h = 0;
            1: h = 255;
            default: h = int'($urandom % 256);
          endcase
          set_gen(g, 1 + int'($urandom % 12), h,
                  ($urandom % 4 == 0) ? int'($urandom % 256) : 255 - h);
        end
      end
      for (int k = 0; k < NC; k++) begin
        m_en[k] = int'($urandom % 4 != 0);
        m_idx[k] = int'($urandom % NG);
      end
      for (int w = 0; w < 5; w++) write_map_word(w);
      for (int t = 0; t < 30; t++) begin
        if (t == 13) set_gen(int'($urandom % NG), 1 + int'($urandom % 12),
                             int'($urandom % 256), int'($urandom % 256));
        do_tick();
        sweep("R2");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule